// File: doc/BRIEF.md
# Page-Mode Read Burst Engine

This block reads short bursts of 16-bit words from an asynchronous pseudo-SRAM that supports a four-word page read. A requester supplies a start address and a word count on a valid/ready request port. The engine selects the memory and waits out one full random-access time for the first word. Each further word in the same four-word page is then fetched by stepping only the two lowest address bits, and costs only the much shorter page time. Each word is handed downstream on a valid/ready stream, and the final word of the burst is marked.

The memory refreshes itself in the background. It therefore must not be held in a run of short accesses for longer than a fixed dwell budget. The engine keeps a dwell counter for every selection. It never lets one selection exceed the budget: a burst is cut into a new selection when the budget would be overrun, and also when downstream back-pressure holds a word for too long. A burst that runs past the end of a page is split the same way. The chip is deselected for at least one full read-cycle time, and a new full access opens the next page. All timing figures are given as clock-cycle counts.

Top module: `page_burst_reader`

## Requirements
- R1: After reset the memory is deselected (`mem_ce_n`=1, `mem_oe_n`=1, `mem_we_n`=1), `out_valid` is 0 and `req_ready` is 1.
- R2: A request is taken only while `req_ready` is 1, and `req_ready` is 0 for the whole of a burst. A request with a word count of 0 is consumed without selecting the memory and without producing any output word.
- R3: A request for N words (N ≥ 1) yields exactly N output words. They carry the memory contents at the start address, start address + 1, and so on in ascending order, and `out_last` is 1 on the N-th word only.
- R4: The first word of every selection is sampled FULL_CYC clock cycles after the chip is selected with its address. Every later word is sampled PAGE_CYC cycles after its low address bits changed.
- R5: While the memory stays selected from one cycle to the next, `mem_addr[AW-1:2]` does not change, and `mem_addr[1:0]` either holds or increases by exactly one.
- R6: A burst that continues past a word whose address ends in binary 11 deselects the memory for at least GAP_CYC cycles, then starts a new full access at the next address. With `out_ready` held at 1, a burst makes exactly one selection for each four-word page it touches.
- R7: The memory is never selected for more than LIMIT_CYC consecutive cycles. This holds even when `out_ready` stays 0: the engine deselects, keeps the held word, and fetches the remaining words with a fresh full access.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_addr | input | AW | Word address of the first word |
| req_len | input | LEN_W | Number of words to read (0 = no access) |
| out_valid | output | 1 | A fetched word is presented |
| out_ready | input | 1 | Downstream takes the presented word |
| out_data | output | DW | Fetched word |
| out_last | output | 1 | Presented word is the last of the burst |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, held inactive (high) |
| mem_addr | output | AW | Memory word address |
| mem_dq | input | DW | Memory read data |

## Verification
The bench builds the engine with a 23-bit address, a 4-bit word count, FULL_CYC=7, PAGE_CYC=3, GAP_CYC=7 and LIMIT_CYC=40. At a 10 ns clock these counts match the 70 ns, 30 ns and 70 ns figures. The small dwell limit means the bench can force a back-pressure split in a few dozen cycles. The memory model returns garbage unless the chip has been selected for FULL_CYC cycles and the address has been stable for PAGE_CYC cycles, so an access that samples early shows up as wrong data. A sweep over every start offset within two pages and every length from 1 to 9 covers all page-crossing patterns. A burst that wraps at the top of the address space and a zero-length request are also run.

// File: rtl/pgr_pkg.sv
// Shared types and helpers for the page-mode read burst engine.
package pgr_pkg;

    // Sequencer phases: idle, full random access, intra-page access,
    // word presented downstream, deselect gap.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_FULL = 3'd1,
        ST_PAGE = 3'd2,
        ST_SHOW = 3'd3,
        ST_GAP  = 3'd4
    } pgr_state_t;

    // Bits needed to hold the values 0..v.
    function automatic int pgr_bits(input int v);
        return (v < 1) ? 1 : $clog2(v + 1);
    endfunction

    // Larger of three counts.
    function automatic int pgr_max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pgr_dwell_guard.sv
// Dwell guard: counts the cycles of the current chip selection.
// It tells the sequencer whether one more page step still fits inside
// the limit, and when a held word has used the whole budget.
// Assumes: clear pulses in the cycle before a new selection starts,
// so that the first selected cycle sees a count of zero.
module pgr_dwell_guard #(
    parameter int LIMIT_CYC = 170,
    parameter int PAGE_CYC  = 3,
    parameter int WD_W      = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,     // a new full access begins next cycle
    input  logic active,    // memory currently selected
    output logic near_end,  // current cycle is the last allowed one
    output logic room       // a page step plus one presented cycle still fits
);

    logic [WD_W-1:0] dwell;

    // Count selected cycles, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dwell <= '0;
        end else if (clear) begin
            dwell <= '0;
        end else if (active && (32'(dwell) < LIMIT_CYC)) begin
            dwell <= dwell + 1'b1;
        end
    end

    // Budget decisions for the sequencer.
    always_comb begin
        near_end = (32'(dwell) + 1) >= LIMIT_CYC;
        room     = (32'(dwell) + PAGE_CYC + 2) <= LIMIT_CYC;
    end

endmodule

// File: rtl/pgr_word_stage.sv
// Output word stage: latches the sampled memory word, presents it with
// valid/ready, and holds it unchanged until it is taken.
// Assumes: cap_en never fires while a word is still waiting.
module pgr_word_stage #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic          cap_last,
    input  logic [DW-1:0] dq,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          out_last,
    output logic          fire
);

    // Capture a word on cap_en, drop valid once it is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else if (cap_en) begin
            out_valid <= 1'b1;
            out_data  <= dq;
            out_last  <= cap_last;
        end else if (fire) begin
            out_valid <= 1'b0;
        end
    end

    // Handshake completion.
    always_comb fire = out_valid && out_ready;

endmodule

// File: rtl/pgr_sequencer.sv
// Burst sequencer: walks a request through full accesses, page steps,
// output hand-off and deselect gaps. It owns the chip select and address.
// Assumes: the dwell guard is cleared on every entry to a full access,
// and FULL_CYC + 1 <= LIMIT_CYC.
module pgr_sequencer
    import pgr_pkg::*;
#(
    parameter int AW       = 23,
    parameter int LEN_W    = 4,
    parameter int FULL_CYC = 7,
    parameter int PAGE_CYC = 3,
    parameter int GAP_CYC  = 7,
    parameter int CNT_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_addr,
    input  logic [LEN_W-1:0] req_len,
    output logic             req_ready,
    input  logic             out_fire,
    input  logic             near_end,
    input  logic             room,
    output logic             sel,
    output logic [AW-1:0]    addr,
    output logic             cap_en,
    output logic             cap_last,
    output logic             wd_clear
);

    localparam logic [CNT_W-1:0] FULL_LD = CNT_W'(FULL_CYC - 1);
    localparam logic [CNT_W-1:0] PAGE_LD = CNT_W'(PAGE_CYC - 1);
    localparam logic [CNT_W-1:0] GAP_LD  = CNT_W'(GAP_CYC - 1);

    pgr_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [LEN_W-1:0] remain;
    logic             start_req;
    logic             gap_done;
    logic             need_break;

    // Decode conditions shared by the state register and the outputs.
    always_comb begin
        start_req  = (state == ST_IDLE) && req_valid && (req_len != '0);
        gap_done   = (state == ST_GAP) && (cnt == '0);
        need_break = (addr[1:0] == 2'b11) || !sel || !room;
        req_ready  = (state == ST_IDLE);
        cap_en     = ((state == ST_FULL) || (state == ST_PAGE)) && (cnt == '0);
        cap_last   = (remain == LEN_W'(1));
        wd_clear   = start_req || (gap_done && (remain != '0));
    end

    // Phase sequencing, address stepping and chip-select control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            addr   <= '0;
            remain <= '0;
            sel    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start_req) begin
                        addr   <= req_addr;
                        remain <= req_len;
                        cnt    <= FULL_LD;
                        sel    <= 1'b1;
                        state  <= ST_FULL;
                    end
                end
                ST_FULL, ST_PAGE: begin
                    if (cnt == '0) begin
                        remain <= remain - 1'b1;
                        state  <= ST_SHOW;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_SHOW: begin
                    if (out_fire) begin
                        if (remain == '0) begin
                            sel   <= 1'b0;
                            cnt   <= GAP_LD;
                            state <= ST_GAP;
                        end else if (need_break) begin
                            sel   <= 1'b0;
                            addr  <= addr + 1'b1;
                            cnt   <= GAP_LD;
                            state <= ST_GAP;
                        end else begin
                            addr  <= addr + 1'b1;
                            cnt   <= PAGE_LD;
                            state <= ST_PAGE;
                        end
                    end else if (sel && near_end) begin
                        sel <= 1'b0;
                    end
                end
                ST_GAP: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (remain != '0) begin
                        cnt   <= FULL_LD;
                        sel   <= 1'b1;
                        state <= ST_FULL;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/page_burst_reader.sv
// Page-mode read burst engine for an asynchronous pseudo-SRAM.
// It takes (address, count) requests and streams the words out.
// Only the first word of each selection pays the full access time, and
// selections are capped in length so that the memory can refresh itself.
// Assumes: all timing parameters are whole clock cycles that already meet
// the memory's access, page, read-cycle and dwell limits.
module page_burst_reader
    import pgr_pkg::*;
#(
    parameter int AW        = 23,
    parameter int DW        = 16,
    parameter int LEN_W     = 4,
    parameter int FULL_CYC  = 7,
    parameter int PAGE_CYC  = 3,
    parameter int GAP_CYC   = 7,
    parameter int LIMIT_CYC = 170
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [AW-1:0]    req_addr,
    input  logic [LEN_W-1:0] req_len,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [DW-1:0]    out_data,
    output logic             out_last,
    output logic             mem_ce_n,
    output logic             mem_oe_n,
    output logic             mem_we_n,
    output logic [AW-1:0]    mem_addr,
    input  logic [DW-1:0]    mem_dq
);

    localparam int CNT_W = pgr_bits(pgr_max3(FULL_CYC, PAGE_CYC, GAP_CYC));
    localparam int WD_W  = pgr_bits(LIMIT_CYC);

    logic sel;
    logic cap_en;
    logic cap_last;
    logic wd_clear;
    logic near_end;
    logic room;
    logic fire;

    pgr_sequencer #(
        .AW(AW), .LEN_W(LEN_W), .FULL_CYC(FULL_CYC), .PAGE_CYC(PAGE_CYC),
        .GAP_CYC(GAP_CYC), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .req_ready(req_ready), .out_fire(fire),
        .near_end(near_end), .room(room), .sel(sel), .addr(mem_addr),
        .cap_en(cap_en), .cap_last(cap_last), .wd_clear(wd_clear)
    );

    pgr_dwell_guard #(
        .LIMIT_CYC(LIMIT_CYC), .PAGE_CYC(PAGE_CYC), .WD_W(WD_W)
    ) u_guard (
        .clk(clk), .rst_n(rst_n), .clear(wd_clear), .active(sel),
        .near_end(near_end), .room(room)
    );

    pgr_word_stage #(.DW(DW)) u_stage (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_last(cap_last),
        .dq(mem_dq), .out_ready(out_ready), .out_valid(out_valid),
        .out_data(out_data), .out_last(out_last), .fire(fire)
    );

    // Memory strobes follow the registered select; writes are never issued.
    always_comb begin
        mem_ce_n = !sel;
        mem_oe_n = !sel;
        mem_we_n = 1'b1;
    end

endmodule

// File: rtl/page_burst_reader_chk.sv
// Protocol checker for page_burst_reader, attached by bind.
// Watches the port-level rules: reset state, stable page address while
// selected, minimum deselect gap, dwell limit and output hold.
module page_burst_reader_chk #(
    parameter int AW        = 23,
    parameter int DW        = 16,
    parameter int GAP_CYC   = 7,
    parameter int LIMIT_CYC = 170
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_data,
    input logic          out_last,
    input logic          mem_ce_n,
    input logic          mem_oe_n,
    input logic [AW-1:0] mem_addr
);

    int unsigned sel_run;
    int unsigned hi_run;
    logic        seen_sel;

    // Track run lengths of selected and deselected cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_run  <= 0;
            hi_run   <= 0;
            seen_sel <= 1'b0;
        end else begin
            sel_run <= mem_ce_n ? 0 : sel_run + 1;
            hi_run  <= mem_ce_n ? hi_run + 1 : 0;
            if (!mem_ce_n) seen_sel <= 1'b1;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (mem_ce_n && mem_oe_n && !out_valid && req_ready));

    p_no_out_when_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && out_valid));

    p_page_bits_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> (mem_addr[AW-1:2] == $past(mem_addr[AW-1:2])));

    p_low_bits_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |->
            ((mem_addr[1:0] == $past(mem_addr[1:0])) ||
             (mem_addr[1:0] == $past(mem_addr[1:0]) + 2'd1)));

    p_gap_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_ce_n) && seen_sel) |-> (hi_run >= GAP_CYC));

    p_dwell_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> (sel_run < LIMIT_CYC));

    p_hold_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_data) && $stable(out_last)));

endmodule

bind page_burst_reader page_burst_reader_chk #(
    .AW(AW), .DW(DW), .GAP_CYC(GAP_CYC), .LIMIT_CYC(LIMIT_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr)
);

// File: tb/sim_page_burst_reader.sv
// Self-checking bench: timing-aware memory model, sweep of start offsets
// and lengths, wrap, zero-length and back-pressure split cases.
module sim_page_burst_reader;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 23;
    localparam int DW    = 16;
    localparam int LEN_W = 4;
    localparam int FULL  = 7;
    localparam int PAGE  = 3;
    localparam int GAP   = 7;
    localparam int LIMIT = 40;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [AW-1:0]    req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic             out_valid;
    logic             out_ready = 1'b1;
    logic [DW-1:0]    out_data;
    logic             out_last;
    logic             mem_ce_n;
    logic             mem_oe_n;
    logic             mem_we_n;
    logic [AW-1:0]    mem_addr;
    logic [DW-1:0]    mem_dq;

    int n_tests = 0;
    int n_fail  = 0;

    page_burst_reader #(
        .AW(AW), .DW(DW), .LEN_W(LEN_W), .FULL_CYC(FULL), .PAGE_CYC(PAGE),
        .GAP_CYC(GAP), .LIMIT_CYC(LIMIT)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dq(mem_dq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [DW-1:0] mdata(input logic [AW-1:0] a);
        return a[15:0] ^ 16'hA5C3;
    endfunction

    // Memory model state and select/gap monitor, advanced at falling edges.
    int          sel_cnt = 0;
    int          addr_cnt = 0;
    logic [AW-1:0] prev_addr = '0;
    logic        prev_ce = 1'b1;
    int          n_sel = 0;
    int          lo_run = 0;
    int          max_lo = 0;
    int          hi_run = 0;
    int          min_hi = 1000;
    logic        seen = 1'b0;

    always @(negedge clk) begin
        sel_cnt  = mem_ce_n ? 0 : sel_cnt + 1;
        addr_cnt = (mem_addr != prev_addr) ? 1 : addr_cnt + 1;
        prev_addr = mem_addr;
        if (!mem_ce_n) begin
            lo_run++;
            if (lo_run > max_lo) max_lo = lo_run;
            if (prev_ce) begin
                n_sel++;
                if (seen && hi_run < min_hi) min_hi = hi_run;
                seen = 1'b1;
            end
            hi_run = 0;
        end else begin
            hi_run++;
            lo_run = 0;
        end
        prev_ce = mem_ce_n;
    end

    // Data is only valid once full access and page timing have elapsed.
    assign mem_dq = (!mem_ce_n && !mem_oe_n && sel_cnt >= FULL && addr_cnt >= PAGE)
                    ? mdata(mem_addr) : 16'hBAD0;

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Run one burst; stall_cycles > 0 holds out_ready low on the first word.
    task automatic burst(input logic [AW-1:0] a, input int len, input int pages,
                         input int stall_cycles);
        int sel0;
        int got;
        logic bad_order;
        logic bad_last;
        logic bad_hold;
        sel0 = n_sel;
        got = 0;
        bad_order = 1'b0;
        bad_last = 1'b0;
        bad_hold = 1'b0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_addr  = a;
        req_len   = LEN_W'(len);
        req_valid = 1'b1;
        if (stall_cycles > 0) out_ready = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R2 busy after accept", 32'(req_ready), 0);
        for (int i = 0; i < len; i++) begin
            while (!out_valid) @(negedge clk);
            if (out_data != mdata(a + AW'(i))) begin
                if (!bad_order)
                    check(1'b0, "R3/R4 word data", 32'(out_data), 32'(mdata(a + AW'(i))));
                bad_order = 1'b1;
            end
            if (out_last != (i == len - 1)) bad_last = 1'b1;
            if (i == 0 && stall_cycles > 0) begin
                for (int s = 0; s < stall_cycles; s++) begin
                    @(negedge clk);
                    if (!out_valid || out_data != mdata(a)) bad_hold = 1'b1;
                end
                check(!bad_hold, "R8 held word stable", 32'(out_data), 32'(mdata(a)));
                out_ready = 1'b1;
            end
            got++;
            @(negedge clk);
        end
        while (!req_ready) begin
            if (out_valid) got++;
            @(negedge clk);
        end
        check(got == len, "R3 word count", 32'(got), 32'(len));
        check(!bad_order, "R3/R4 data order", 32'(bad_order), 0);
        check(!bad_last, "R3 last flag", 32'(bad_last), 0);
        check(n_sel - sel0 == pages, "R6/R7 selection count", 32'(n_sel - sel0), 32'(pages));
    endtask

    // Hang guard: an expired run counts as a failure and still reports.
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: reset state
        check(mem_ce_n == 1'b1, "R1 ce_n", 32'(mem_ce_n), 1);
        check(mem_oe_n == 1'b1, "R1 oe_n", 32'(mem_oe_n), 1);
        check(mem_we_n == 1'b1, "R1 we_n", 32'(mem_we_n), 1);
        check(!out_valid, "R1 out_valid", 32'(out_valid), 0);
        check(req_ready, "R1 req_ready", 32'(req_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: zero-length request selects nothing and outputs nothing
        begin
            int s0;
            logic any_out;
            s0 = n_sel;
            any_out = 1'b0;
            req_addr = AW'(32'h55);
            req_len = '0;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            for (int k = 0; k < 20; k++) begin
                if (out_valid) any_out = 1'b1;
                @(negedge clk);
            end
            check(n_sel == s0, "R2 zero length no select", 32'(n_sel - s0), 0);
            check(!any_out, "R2 zero length no output", 32'(any_out), 0);
            check(req_ready, "R2 ready after zero length", 32'(req_ready), 1);
        end

        // R3/R4/R6: sweep start offsets across two pages and lengths 1..9
        for (int off = 0; off < 8; off++) begin
            for (int len = 1; len <= 9; len++) begin
                int base;
                base = 32'h40 + off;
                burst(AW'(base), len, ((base + len - 1) >> 2) - (base >> 2) + 1, 0);
            end
        end

        // R6: burst wrapping at the top of the address space spans two pages
        burst(AW'(23'h7FFFFE), 4, 2, 0);

        // R7/R8: long back-pressure on the first word forces one extra selection
        burst(AW'(32'h81), 3, 2, 60);

        check(max_lo <= LIMIT, "R7 longest selection", 32'(max_lo), LIMIT);
        check(min_hi >= GAP, "R6 shortest gap", 32'(min_hi), GAP);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule